// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Controller

This block gives a processor a small bank of 32-bit registers for sending and receiving asynchronous serial characters. Each character is 8 data bits, least significant bit first, with one start bit and one stop bit. A write to the data word starts a transmit frame on the serial output. A frame that arrives on the serial input is stored in the data word, but only while the controller and its receiver are both switched on and no earlier character is still waiting to be read. Three flags report progress: data-read (bit 7), frame-complete (bit 6) and character-waiting (bit 5). A single interrupt line follows the character-waiting flag when the receive interrupt enable is set.

The bit period, in system clock cycles, is the value held in the baud word. The host reads and writes through a plain strobe port. Read data appears on the bus one clock after the read strobe. Three more words (control-2, control-3 and guard time) only store what the host writes to them.

Top module: `sercon`

## Requirements
- R1: After reset the status word (offset 0x00) reads 0x00C00000. The data word (0x04), baud word (0x08) and control-1 (0x0C) read 0. The serial output is high and the interrupt is low.
- R2: The baud word (0x08), control-1 (0x0C), control-2 (0x10), control-3 (0x14) and guard word (0x18) each read back the full 32-bit value last written. Offset 0x1C and any address that is not word aligned read 0.
- R3: A status write with a value of at most 0x3FF replaces the status word. A status write with a larger value is ANDed into the current status word.
- R4: A status read returns the status word as it was before the read, and then clears frame-complete (bit 6).
- R5: A data read returns the low 10 bits of the data word, zero-extended. It then sets data-read (bit 7) and clears character-waiting (bit 5).
- R6: A received 8N1 frame is sampled near mid-bit, with a bit period equal to the baud word (values below 2 count as 2). The frame is accepted when control-1 has both the controller enable (bit 13) and the receive enable (bit 2) set. An accepted character is latched into the data word and sets character-waiting.
- R7: A received frame is discarded if either the controller enable (bit 13) or the receive enable (bit 2) is clear. The data word and character-waiting are left unchanged.
- R8: While character-waiting is set, a newly received frame is discarded and the data word keeps the first character.
- R9: The interrupt is high while character-waiting and the receive interrupt enable (control-1 bit 5) are both set. It drops within two cycles after a data read clears character-waiting.
- R10: A data write sends its low 8 bits as one 8N1 frame on the serial output, one baud-word period per bit. Frame-complete is set once the stop bit has finished. A data write made while a frame is still being sent is ignored.
- R11: A received frame whose stop bit is low is discarded. The receiver then waits for the line to go high before it looks for the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Receive interrupt |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |

## Verification
The assertions rely on three conditions at the inputs. The host never asserts read and write in the same cycle. The baud word does not change while a frame is in flight. The incoming line holds each bit for a whole baud period. The stimulus meets these conditions in the following ways:
- It programs the baud word once, to 4, before any serial traffic.
- It keeps every bus access a single strobe.
- It drives each incoming bit for exactly four clocks, and leaves an idle gap of several bit periods between frames.

// File: rtl/sercon_pkg.sv
package sercon_pkg;

  typedef enum logic [2:0] {
    REG_STAT  = 3'd0,
    REG_DATA  = 3'd1,
    REG_BAUD  = 3'd2,
    REG_CTL1  = 3'd3,
    REG_CTL2  = 3'd4,
    REG_CTL3  = 3'd5,
    REG_GUARD = 3'd6
  } reg_sel_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_e;

  // status word flag positions
  localparam int ST_DREAD = 7;
  localparam int ST_DONE  = 6;
  localparam int ST_AVAIL = 5;

  // control-1 bit positions
  localparam int CT_ON   = 13;
  localparam int CT_RXIE = 5;
  localparam int CT_RXON = 2;

  localparam logic [31:0] STAT_INIT     = 32'h00C0_0000;
  localparam logic [31:0] STAT_LOAD_MAX = 32'h0000_03FF;
  localparam int          DATA_RD_BITS  = 10;
  localparam int          CHAR_BITS     = 8;

endpackage

// File: rtl/sercon_bitclk.sv
module sercon_bitclk #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             half,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] cnt;

  always_comb div_eff = (div < DIV_MIN) ? DIV_MIN : div;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= (half ? (div_eff >> 1) : div_eff) - 1'b1;
    end else if (cnt == '0) begin
      cnt <= div_eff - 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign tick = (cnt == '0) && !restart;

endmodule

// File: rtl/sercon_tx.sv
module sercon_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       data,
  input  logic [DIV_W-1:0] div,
  output logic             txd,
  output logic             busy,
  output logic             done
);
  localparam int FRAME_BITS = 10;

  logic [FRAME_BITS-1:0] shreg;
  logic [3:0]            nbit;
  logic                  go;
  logic                  tick;

  assign go = start && !busy;

  sercon_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk     (clk),
    .rst     (rst),
    .restart (go),
    .half    (1'b0),
    .div     (div),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '1;
      nbit  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      txd   <= 1'b1;
    end else begin
      done <= 1'b0;
      txd  <= busy ? shreg[0] : 1'b1;
      if (go) begin
        shreg <= {1'b1, data, 1'b0};
        nbit  <= '0;
        busy  <= 1'b1;
      end else if (busy && tick) begin
        shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
        if (nbit == 4'(FRAME_BITS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          nbit <= nbit + 1'b1;
        end
      end
    end
  end

  // R10: completion only ends a frame that was running
  p_done_ends_frame_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));

  // R10: the line rests high when no frame was in flight
  p_idle_line_high_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> txd);

endmodule

// File: rtl/sercon_rx.sv
module sercon_rx
  import sercon_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd,
  input  logic [DIV_W-1:0] div,
  output logic             done,
  output logic [7:0]       rx_byte
);
  logic       sync1, sync2;
  rx_state_e  state;
  logic [2:0] nbit;
  logic [7:0] shreg;
  logic       tick;
  logic       restart;

  assign restart = (state == RX_IDLE) && !sync2;

  sercon_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .half    (1'b1),
    .div     (div),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1   <= 1'b1;
      sync2   <= 1'b1;
      state   <= RX_IDLE;
      nbit    <= '0;
      shreg   <= '0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      sync1 <= rxd;
      sync2 <= sync1;
      done  <= 1'b0;
      case (state)
        RX_IDLE: if (!sync2) state <= RX_START;
        RX_START: if (tick) begin
          state <= sync2 ? RX_IDLE : RX_DATA;
          nbit  <= '0;
        end
        RX_DATA: if (tick) begin
          shreg <= {sync2, shreg[7:1]};
          if (nbit == 3'd7) state <= RX_STOP;
          else nbit <= nbit + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (sync2) begin
            done    <= 1'b1;
            rx_byte <= shreg;
            state   <= RX_IDLE;
          end else begin
            state <= RX_WAIT_HIGH;
          end
        end
        RX_WAIT_HIGH: if (sync2) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R11: a character is only delivered straight out of the stop-bit phase
  p_done_from_stop_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(state) == RX_STOP && $past(sync2)));

endmodule

// File: rtl/sercon.sv
module sercon
  import sercon_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              rxd,
  output logic              txd
);
  logic [31:0] stat_q, data_q, baud_q, ctl1_q, ctl2_q, ctl3_q, guard_q;
  logic [31:0] stat_d;
  reg_sel_e    sel;
  logic        aligned;
  logic        wr_stat, rd_stat, wr_data, rd_data;
  logic        tx_busy, tx_done;
  logic        rx_done, rx_accept;
  logic [7:0]  rx_byte;

  assign sel     = reg_sel_e'(bus_addr[4:2]);
  assign aligned = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);
  assign wr_stat = bus_wr && aligned && (sel == REG_STAT);
  assign rd_stat = bus_rd && aligned && (sel == REG_STAT);
  assign wr_data = bus_wr && aligned && (sel == REG_DATA);
  assign rd_data = bus_rd && aligned && (sel == REG_DATA);

  assign rx_accept = rx_done && ctl1_q[CT_ON] && ctl1_q[CT_RXON] && !stat_q[ST_AVAIL];

  sercon_tx #(.DIV_W(DIV_W)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .start (wr_data),
    .data  (bus_wdata[7:0]),
    .div   (baud_q[DIV_W-1:0]),
    .txd   (txd),
    .busy  (tx_busy),
    .done  (tx_done)
  );

  sercon_rx #(.DIV_W(DIV_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .rxd     (rxd),
    .div     (baud_q[DIV_W-1:0]),
    .done    (rx_done),
    .rx_byte (rx_byte)
  );

  // status: host access first, hardware events take precedence
  always_comb begin
    stat_d = stat_q;
    if (wr_stat) stat_d = (bus_wdata <= STAT_LOAD_MAX) ? bus_wdata : (stat_q & bus_wdata);
    if (rd_stat) stat_d[ST_DONE] = 1'b0;
    if (rd_data) begin
      stat_d[ST_DREAD] = 1'b1;
      stat_d[ST_AVAIL] = 1'b0;
    end
    if (tx_done)   stat_d[ST_DONE]  = 1'b1;
    if (rx_accept) stat_d[ST_AVAIL] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= STAT_INIT;
      data_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (rx_accept) data_q <= {24'b0, rx_byte};
      irq <= ctl1_q[CT_RXIE] && stat_q[ST_AVAIL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baud_q  <= '0;
      ctl1_q  <= '0;
      ctl2_q  <= '0;
      ctl3_q  <= '0;
      guard_q <= '0;
    end else if (bus_wr && aligned) begin
      case (sel)
        REG_BAUD:  baud_q  <= bus_wdata;
        REG_CTL1:  ctl1_q  <= bus_wdata;
        REG_CTL2:  ctl2_q  <= bus_wdata;
        REG_CTL3:  ctl3_q  <= bus_wdata;
        REG_GUARD: guard_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd && aligned) begin
      case (sel)
        REG_STAT:  bus_rdata <= stat_q;
        REG_DATA:  bus_rdata <= {{(32-DATA_RD_BITS){1'b0}}, data_q[DATA_RD_BITS-1:0]};
        REG_BAUD:  bus_rdata <= baud_q;
        REG_CTL1:  bus_rdata <= ctl1_q;
        REG_CTL2:  bus_rdata <= ctl2_q;
        REG_CTL3:  bus_rdata <= ctl3_q;
        REG_GUARD: bus_rdata <= guard_q;
        default:   bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end

  // R6: an accepted character lands in the data word and raises the flag
  p_rx_latch_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_done && ctl1_q[CT_ON] && ctl1_q[CT_RXON] && !stat_q[ST_AVAIL])
      |=> (stat_q[ST_AVAIL] && data_q[7:0] == $past(rx_byte)));

  // R7: with either enable off the data word does not move
  p_rx_gated_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !(ctl1_q[CT_ON] && ctl1_q[CT_RXON])) |=> $stable(data_q));

  // R8: a waiting character is never overwritten
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_done && stat_q[ST_AVAIL]) |=> $stable(data_q));

  // R4: a status read leaves frame-complete low unless a frame ends then
  p_done_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !wr_stat && !tx_done) |=> !stat_q[ST_DONE]);

  // R9: interrupt follows the waiting flag down
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_q[ST_AVAIL]) |=> !irq);

endmodule

// File: tb/test_sercon.sv
`timescale 1ns/1ps
module test_sercon;
  localparam int BIT = 4;
  localparam logic [4:0] A_STAT = 5'h00, A_DATA = 5'h04, A_BAUD = 5'h08,
                         A_CTL1 = 5'h0C, A_CTL2 = 5'h10, A_CTL3 = 5'h14,
                         A_GUARD = 5'h18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, txd;
  logic        rxd = 1'b1;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sercon i_sercon (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rxd(rxd), .txd(txd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send(input logic [7:0] b, input bit stop);
    logic [9:0] fr;
    fr = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rxd = fr[i];
      repeat (BIT - 1) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT) @(negedge clk);
  endtask

  task automatic grab_frame(output logic [9:0] fr, output bit seen);
    seen = 1'b0;
    fr = '1;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (txd == 1'b0) seen = 1'b1;
      else @(negedge clk);
    end
    if (seen) begin
      repeat (BIT / 2) @(negedge clk);
      for (int i = 0; i < 10; i++) begin
        fr[i] = txd;
        if (i < 9) repeat (BIT) @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [9:0]  fr;
    bit          seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(txd == 1'b1, "R1 txd", {31'b0, txd}, 32'h1);
    chk(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'h0);
    rd(A_STAT, v); chk(v == 32'h00C0_0000, "R1 status", v, 32'h00C0_0000);
    rd(A_DATA, v); chk(v == 32'h0, "R1 data", v, 32'h0);
    rd(A_BAUD, v); chk(v == 32'h0, "R1 baud", v, 32'h0);
    rd(A_CTL1, v); chk(v == 32'h0, "R1 ctl1", v, 32'h0);

    // R2 storage and decode
    wr(A_BAUD, 32'h1234_5678); rd(A_BAUD, v); chk(v == 32'h1234_5678, "R2 baud", v, 32'h1234_5678);
    wr(A_CTL2, 32'hDEAD_BEEF); rd(A_CTL2, v); chk(v == 32'hDEAD_BEEF, "R2 ctl2", v, 32'hDEAD_BEEF);
    wr(A_CTL3, 32'hA5A5_0F0F); rd(A_CTL3, v); chk(v == 32'hA5A5_0F0F, "R2 ctl3", v, 32'hA5A5_0F0F);
    wr(A_GUARD, 32'h0000_FFFF); rd(A_GUARD, v); chk(v == 32'h0000_FFFF, "R2 guard", v, 32'h0000_FFFF);
    wr(A_CTL1, 32'h8000_0001); rd(A_CTL1, v); chk(v == 32'h8000_0001, "R2 ctl1", v, 32'h8000_0001);
    rd(5'h1C, v); chk(v == 32'h0, "R2 unmapped", v, 32'h0);
    rd(5'h0A, v); chk(v == 32'h0, "R2 misaligned", v, 32'h0);
    wr(A_BAUD, BIT);
    wr(A_CTL1, 32'h0);

    // R3 / R4 status write and read rules
    wr(A_STAT, 32'h0000_00E0);
    rd(A_STAT, v); chk(v == 32'h0000_00E0, "R3 direct load", v, 32'hE0);
    rd(A_STAT, v); chk(v == 32'h0000_00A0, "R4 read clears bit6", v, 32'hA0);
    wr(A_STAT, 32'hFFFF_FF7F);
    rd(A_STAT, v); chk(v == 32'h0000_0020, "R3 and-merge", v, 32'h20);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk(v == 32'h0, "R3 clear", v, 32'h0);

    // R6 receive sweep over every character value
    wr(A_CTL1, 32'h0000_200C);
    for (int b = 0; b < 256; b++) begin
      send(8'(b), 1'b1);
      rd(A_DATA, v);
      chk(v == 32'(b), "R6 receive", v, 32'(b));
    end

    // R5 data read side effects
    send(8'h3C, 1'b1);
    rd(A_STAT, v); chk(v[5] == 1'b1, "R6 avail set", v, 32'h20);
    rd(A_DATA, v); chk(v == 32'h3C, "R5 data low bits", v, 32'h3C);
    rd(A_STAT, v); chk(v[7] == 1'b1 && v[5] == 1'b0, "R5 flags", v, 32'h80);

    // R7 enables gate reception
    wr(A_CTL1, 32'h0000_2000);
    send(8'h5A, 1'b1);
    rd(A_STAT, v); chk(v[5] == 1'b0, "R7 no avail (rx off)", v, 32'h0);
    rd(A_DATA, v); chk(v == 32'h3C, "R7 data kept (rx off)", v, 32'h3C);
    wr(A_CTL1, 32'h0000_0004);
    send(8'h5B, 1'b1);
    rd(A_STAT, v); chk(v[5] == 1'b0, "R7 no avail (off)", v, 32'h0);
    rd(A_DATA, v); chk(v == 32'h3C, "R7 data kept (off)", v, 32'h3C);

    // R8 no overwrite while a character waits
    wr(A_CTL1, 32'h0000_2004);
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    rd(A_DATA, v); chk(v == 32'h11, "R8 first kept", v, 32'h11);
    send(8'h33, 1'b1);
    rd(A_DATA, v); chk(v == 32'h33, "R8 accepts after read", v, 32'h33);

    // R9 interrupt
    send(8'h44, 1'b1);
    chk(irq == 1'b0, "R9 irq masked", {31'b0, irq}, 32'h0);
    rd(A_DATA, v);
    wr(A_CTL1, 32'h0000_2024);
    send(8'h45, 1'b1);
    chk(irq == 1'b1, "R9 irq raised", {31'b0, irq}, 32'h1);
    rd(A_DATA, v);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9 irq dropped", {31'b0, irq}, 32'h0);

    // R11 bad stop bit then recovery
    send(8'h77, 1'b0);
    rd(A_STAT, v); chk(v[5] == 1'b0, "R11 framing drop", v, 32'h0);
    send(8'h66, 1'b1);
    rd(A_DATA, v); chk(v == 32'h66, "R11 recovery", v, 32'h66);

    // R10 transmit sweep
    rd(A_STAT, v);
    for (int k = 0; k < 32; k++) begin
      logic [7:0] tv;
      tv = 8'(k * 37 + 5);
      wr(A_DATA, {24'hABCDEF, tv});
      grab_frame(fr, seen);
      chk(seen && fr[0] == 1'b0 && fr[9] == 1'b1 && fr[8:1] == tv, "R10 tx frame",
          {22'b0, fr}, {22'b0, 1'b1, tv, 1'b0});
      repeat (BIT + 2) @(negedge clk);
      rd(A_STAT, v); chk(v[6] == 1'b1, "R10 frame-complete", v, 32'h40);
    end

    // R10 write while busy is ignored
    wr(A_DATA, 32'hA5);
    wr(A_DATA, 32'h3C);
    grab_frame(fr, seen);
    chk(seen && fr == {1'b1, 8'hA5, 1'b0}, "R10 busy first frame", {22'b0, fr}, {22'b0, 10'h34A});
    repeat (BIT) @(negedge clk);
    begin
      bit quiet;
      quiet = 1'b1;
      for (int i = 0; i < 3 * BIT * 10; i++) begin
        if (txd != 1'b1) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R10 busy write dropped", {31'b0, quiet}, 32'h1);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule